// File: doc/BRIEF.md
# Memory-to-Memory Copy Sequencer

This block copies a run of bytes from one memory region to another by pairing two address channels. The source channel holds the read pointer. The destination channel holds the write pointer and the byte counter. Each byte moves in two bus cycles. A memory read loads the byte into an internal holding register. A memory write then stores that register at the destination address.

Software first loads both channels through a configuration strobe. It then raises a start request on the source channel. A ready input stretches any bus cycle while it is low. The copy stops in one of two ways: the counter runs out, which is the internal end of process, or an external end-of-process input is high when a write finishes. Either way the block raises a one-cycle terminal-count pulse. The source pointer can be frozen so that one value fills the whole destination. The destination pointer can step up or down.

Top module: `mem_copy_seq`

## Requirements
- R1: After reset the block is idle: `mem_rd`, `mem_wr`, `busy` and `tc` are all low.
- R2: When `sw_req` is high in an idle cycle without `cfg_we`, the next cycle is a read cycle (`mem_rd`=1) whose `mem_addr` is the current source pointer.
- R3: A read cycle that completes (`ready`=1) captures `mem_rdata`. The next cycle is a write cycle (`mem_wr`=1) with `mem_addr` equal to the destination pointer and `mem_wdata` equal to the captured byte.
- R4: While `ready` is low, a read or write cycle repeats, and `mem_addr` and `mem_wdata` hold their values.
- R5: Each completed read adds one to the source pointer, unless the hold-source bit loaded by `cfg_we` is 1, in which case the pointer stays fixed.
- R6: Each completed write moves the destination pointer by one. It moves up when the loaded direction bit is 0 and down when it is 1.
- R7: A programmed count of N moves N+1 bytes. The internal end of process occurs when a write completes while the counter is zero. The counter wraps to all ones at that point.
- R8: If `eop_ext` is high in the cycle a write completes, the sequence ends after that write.
- R9: `tc` is high for exactly the one cycle after the final write completes. In that cycle the block is already idle.
- R10: While busy, `cfg_we` and `sw_req` have no effect on the transfer in progress.
- R11: `mem_rd` and `mem_wr` are never high together.
- R12: After the sequence ends, the pointers and the counter keep their updated values, so a later `sw_req` continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Loads the channel settings while idle |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_cnt | input | CW | Byte count minus one |
| cfg_hold | input | 1 | 1 = keep the source address fixed |
| cfg_down | input | 1 | 1 = destination address counts down |
| sw_req | input | 1 | Software start request on the source channel |
| ready | input | 1 | Low inserts wait states into the current cycle |
| eop_ext | input | 1 | External end of process, sampled when a write completes |
| mem_rdata | input | DW | Read data from memory |
| mem_addr | output | AW | Memory address for the current cycle |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| mem_wdata | output | DW | Write data (the holding register) |
| busy | output | 1 | A sequence is in progress |
| tc | output | 1 | Terminal count pulse |

## Verification
The bus outputs come straight from internal state. So a wrong pointer shows up on `mem_addr` in the very next read or write cycle. A stale or corrupt holding register shows up on `mem_wdata` in the write that follows the read. A counter fault shows up only when the sequence ends. In that case `tc` and the return to idle come one byte early or late, and the destination memory shows the wrong number of bytes written. The bench compares every output on every clock against a behavioural model, under constant and random wait states, so any divergence is reported in the cycle it appears.

// File: rtl/mem_copy_seq.sv
module mem_copy_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          cfg_hold,
  input  logic          cfg_down,
  input  logic          sw_req,
  input  logic          ready,
  input  logic          eop_ext,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          tc
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          hold_q, down_q;
  logic [DW-1:0] tmp_q;
  logic          tc_q;

  wire rd_done = (st == S_RD) && ready;
  wire wr_done = (st == S_WR) && ready;
  wire last    = wr_done && ((cnt_q == '0) || eop_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
      down_q <= 1'b0;
      tmp_q  <= '0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= last;
      case (st)
        S_IDLE: begin
          if (cfg_we) begin
            src_q  <= cfg_src;
            dst_q  <= cfg_dst;
            cnt_q  <= cfg_cnt;
            hold_q <= cfg_hold;
            down_q <= cfg_down;
          end else if (sw_req) begin
            st <= S_RD;
          end
        end
        S_RD: begin
          if (rd_done) begin
            tmp_q <= mem_rdata;
            if (!hold_q) src_q <= src_q + 1'b1;
            st <= S_WR;
          end
        end
        S_WR: begin
          if (wr_done) begin
            dst_q <= down_q ? dst_q - 1'b1 : dst_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
            st    <= last ? S_IDLE : S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr  = (st == S_WR) ? dst_q : src_q;
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_wdata = tmp_q;
  assign busy      = (st != S_IDLE);
  assign tc        = tc_q;
endmodule

// File: rtl/mem_copy_seq_chk.sv
module mem_copy_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          eop_ext,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          busy,
  input logic          tc
);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_rd_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !ready |=> mem_rd && $stable(mem_addr));

  assert_wr_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !ready |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

  assert_rd_to_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && ready |=> mem_wr);

  assert_tc_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(mem_wr && ready) && !busy);

  assert_tc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  assert_ext_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && ready && eop_ext |=> tc);
endmodule

bind mem_copy_seq mem_copy_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .eop_ext(eop_ext),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .busy(busy), .tc(tc)
);

// File: tb/mem_copy_seq_tb.sv
module mem_copy_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_cnt = '0;
  logic        cfg_hold = 1'b0, cfg_down = 1'b0;
  logic        sw_req = 1'b0, ready = 1'b1, eop_ext = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, busy, tc;
  logic [7:0]  mem_wdata;

  logic [7:0] mem [256];
  int errors = 0, checks = 0, cyc = 0, tc_seen = 0;
  bit rnd_ready = 0;

  always #2 clk = ~clk;

  mem_copy_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_hold(cfg_hold),
    .cfg_down(cfg_down), .sw_req(sw_req), .ready(ready), .eop_ext(eop_ext),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .tc(tc)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (mem_wr && ready) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  // behavioural reference model
  int          m_st;
  logic [15:0] m_src, m_dst, m_cnt;
  logic        m_hold, m_down, m_tc;
  logic [7:0]  m_tmp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_src = 0; m_dst = 0; m_cnt = 0;
      m_hold = 0; m_down = 0; m_tc = 0; m_tmp = 0;
    end else begin
      m_tc = 0;
      if (m_st == 0) begin
        if (cfg_we) begin
          m_src = cfg_src; m_dst = cfg_dst; m_cnt = cfg_cnt;
          m_hold = cfg_hold; m_down = cfg_down;
        end else if (sw_req) m_st = 1;
      end else if (m_st == 1) begin
        if (ready) begin
          m_tmp = mem[m_src[7:0]];
          if (!m_hold) m_src = m_src + 16'd1;
          m_st = 2;
        end
      end else if (ready) begin
        m_tc = (m_cnt == 0) || eop_ext;
        m_dst = m_down ? m_dst - 16'd1 : m_dst + 16'd1;
        m_cnt = m_cnt - 16'd1;
        m_st = m_tc ? 0 : 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (tc) tc_seen++;
      chk(mem_rd == (m_st == 1), "R2 R11 mem_rd", int'(mem_rd), int'(m_st == 1));
      chk(mem_wr == (m_st == 2), "R3 R4 mem_wr", int'(mem_wr), int'(m_st == 2));
      chk(busy == (m_st != 0), "R10 busy", int'(busy), int'(m_st != 0));
      chk(mem_addr == ((m_st == 2) ? m_dst : m_src), "R5 R6 R12 mem_addr",
          int'(mem_addr), int'((m_st == 2) ? m_dst : m_src));
      if (m_st == 2) chk(mem_wdata == m_tmp, "R3 mem_wdata", int'(mem_wdata), int'(m_tmp));
      chk(tc == m_tc, "R7 R8 R9 tc", int'(tc), int'(m_tc));
    end
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
    ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  endtask

  task automatic load(input int s, input int d, input int n, input bit h, input bit dn);
    cfg_we = 1; cfg_src = 16'(s); cfg_dst = 16'(d); cfg_cnt = 16'(n);
    cfg_hold = h; cfg_down = dn;
    tick();
    cfg_we = 0;
  endtask

  task automatic run();
    sw_req = 1;
    tick();
    sw_req = 0;
    while (busy) tick();
    tick();
  endtask

  initial begin
    int t0;
    tick(); tick();
    // R1 reset state
    chk(!mem_rd && !mem_wr && !busy && !tc, "R1 reset idle",
        {mem_rd, mem_wr, busy, tc}, 0);
    rst_n = 1;
    tick();

    // R2 R3 R5 R6 R7: 4 bytes ascending
    t0 = tc_seen;
    load(16'h10, 16'h80, 3, 0, 0);
    run();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h80 + i] == (8'(8'h10 + i) ^ 8'h5A), "R3 R7 copy up",
          mem[8'h80 + i], 8'(8'h10 + i) ^ 8'h5A);
    chk(mem[8'h84] == (8'h84 ^ 8'h5A), "R7 no extra byte", mem[8'h84], 8'h84 ^ 8'h5A);
    chk(tc_seen - t0 == 1, "R9 one tc pulse", tc_seen - t0, 1);

    // R4 R6: random wait states, destination descending
    rnd_ready = 1;
    load(16'h20, 16'hC0, 5, 0, 1);
    run();
    for (int i = 0; i < 6; i++)
      chk(mem[8'hC0 - i] == (8'(8'h20 + i) ^ 8'h5A), "R4 R6 copy down",
          mem[8'hC0 - i], 8'(8'h20 + i) ^ 8'h5A);

    // R5 hold source: fill
    load(16'h33, 16'h40, 4, 1, 0);
    run();
    for (int i = 0; i < 5; i++)
      chk(mem[8'h40 + i] == (8'h33 ^ 8'h5A), "R5 fill", mem[8'h40 + i], 8'h33 ^ 8'h5A);

    // R8 external end of process after the third write
    rnd_ready = 0;
    load(16'h00, 16'hA0, 10, 0, 0);
    sw_req = 1; tick(); sw_req = 0;
    for (int w = 0; w < 3; w++) begin
      while (!mem_wr) tick();
      if (w == 2) eop_ext = 1;
      tick();
    end
    eop_ext = 0;
    while (busy) tick();
    tick();
    chk(mem[8'hA2] == (8'h02 ^ 8'h5A), "R8 third byte", mem[8'hA2], 8'h02 ^ 8'h5A);
    chk(mem[8'hA3] == (8'hA3 ^ 8'h5A), "R8 stopped", mem[8'hA3], 8'hA3 ^ 8'h5A);

    // R12 resume from updated pointers (count 7 left, moves 8 bytes)
    run();
    chk(mem[8'hAA] == (8'h0A ^ 8'h5A), "R12 resume", mem[8'hAA], 8'h0A ^ 8'h5A);

    // R10 config and request ignored while busy
    load(16'h60, 16'h70, 2, 0, 0);
    sw_req = 1; tick(); sw_req = 1;
    cfg_we = 1; cfg_dst = 16'hF0; cfg_cnt = 16'd20;
    tick(); tick();
    cfg_we = 0; sw_req = 0;
    while (busy) tick();
    tick();
    chk(mem[8'hF0] == (8'hF0 ^ 8'h5A), "R10 cfg ignored", mem[8'hF0], 8'hF0 ^ 8'h5A);
    chk(mem[8'h72] == (8'h62 ^ 8'h5A), "R10 transfer intact", mem[8'h72], 8'h62 ^ 8'h5A);
    chk(mem[8'h73] == (8'h73 ^ 8'h5A), "R10 count kept", mem[8'h73], 8'h73 ^ 8'h5A);

    // R7 count zero moves a single byte
    load(16'h05, 16'hE0, 0, 0, 0);
    run();
    chk(mem[8'hE0] == (8'h05 ^ 8'h5A), "R7 single", mem[8'hE0], 8'h05 ^ 8'h5A);
    chk(mem[8'hE1] == (8'hE1 ^ 8'h5A), "R7 single only", mem[8'hE1], 8'hE1 ^ 8'h5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule